// File: doc/BRIEF.md
# Column-Sum Crosswire Multiplier (4 x 4)

This block multiplies two unsigned 4-bit operands and returns their 8-bit product. It never builds shifted rows of partial products and adds them. Instead it takes each output column in turn, from the least significant up. The value of a column is the count of the operand bit-pairs whose indices add up to that column's weight, plus whatever carry the column below passed up. All bit-pair ANDs are formed at the same time. The lowest bit of each column's total becomes a product bit. The rest of that total, shifted down by one, is handed to the next column. This carry can be more than one bit wide. The carry that leaves the last column supplies the top product bit.

The block is meant to be the leaf multiplier inside a larger multiplier built by splitting operands into halves. A parameter selects one of two forms. In the registered form (the default), the product is captured on the rising clock edge together with a valid flag. In the other form, the product and the flag pass straight through.

Top module: `xw_mul4`

## Requirements
- R1: After reset with the registered output selected, `prod` reads 0 and `prod_vld` reads 0 until a valid operand pair has been taken in.
- R2: Product bit 0 always equals `op_a[0] & op_b[0]` for the captured pair.
- R3: For every one of the 256 unsigned operand pairs, `prod` equals `op_a * op_b`, with bit 7 as the most significant bit.
- R4: Columns whose sums exceed 3 carry multi-bit values upward correctly. For `op_a = op_b = 15` the result is 225 (8'hE1), and bit 7 is driven only by the carry that leaves the highest column.
- R5: With the registered output, `prod_vld` is high in the cycle after the cycle in which `in_vld` was high, and `prod` then holds the product of the pair presented with that `in_vld`.
- R6: In a cycle where `in_vld` is low, the next cycle shows `prod_vld` low and `prod` unchanged, whatever values `op_a` and `op_b` carry.
- R7: A zero operand on either side gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `op_a`/`op_b` as a pair to multiply; acts as the clock enable of the output register |
| op_a | input | 4 | Unsigned multiplicand |
| op_b | input | 4 | Unsigned multiplier |
| prod | output | 8 | Unsigned product |
| prod_vld | output | 1 | Marks `prod` as holding a fresh product |

## Verification
In the registered form, each operand pair that is offered on a clock edge with `in_vld` high produces its product and a raised `prod_vld` one rising edge later. An idle cycle shows its effect (flag low, product held) at the same one-edge distance. The bench changes its inputs on falling edges. A behavioural model, written from the requirements, advances on each rising edge. The bench compares the ports at the falling edge that follows, which is half a period after the register has updated. The sweep covers all 256 pairs in order, with idle cycles mixed in whose operands are garbage.

// File: rtl/xw_mul_pkg.sv
package xw_mul_pkg;

  // Width of a column accumulator: enough for W terms plus the carry
  // arriving from below (column totals never exceed 2*W).
  function automatic int col_sum_width(input int w);
    return $clog2(w) + 3;
  endfunction

  // Number of output columns that receive bit products.
  function automatic int col_count(input int w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/xw_pp_grid.sv
module xw_pp_grid #(
  parameter int W    = 4,
  parameter int NCOL = 2 * W - 1
) (
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            b_i,
  output logic [NCOL-1:0][W-1:0]  col_o
);

  // Slot i of column c holds a[i]&b[c-i] when that index pair exists;
  // every AND is formed at once.
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar i = 0; i < W; i++) begin : g_term
      if ((c - i) >= 0 && (c - i) < W) begin : g_live
        assign col_o[c][i] = a_i[i] & b_i[c-i];
      end else begin : g_void
        assign col_o[c][i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/xw_col_sum.sv
module xw_col_sum #(
  parameter int W    = 4,
  parameter int SUMW = 5
) (
  input  logic [W-1:0]    terms_i,
  input  logic [SUMW-1:0] cin_i,
  output logic            bit_o,
  output logic [SUMW-1:0] cout_o
);

  logic [SUMW-1:0] total;

  always_comb begin
    total = cin_i;
    for (int i = 0; i < W; i++) begin
      total = total + SUMW'(terms_i[i]);
    end
  end

  assign bit_o  = total[0];
  assign cout_o = total >> 1;

endmodule

// File: rtl/xw_out_stage.sv
module xw_out_stage #(
  parameter int PW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [PW-1:0] prod_i,
  output logic [PW-1:0] prod_o,
  output logic          vld_o
);

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q, prod_d;
    logic          vld_q,  vld_d;

    always_comb begin
      prod_d = prod_q;
      if (vld_i) begin
        prod_d = prod_i;
      end
      vld_d = vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        prod_q <= prod_d;
        vld_q  <= vld_d;
      end
    end

    assign prod_o = prod_q;
    assign vld_o  = vld_q;
  end else begin : g_pass
    assign prod_o = prod_i;
    assign vld_o  = vld_i;
  end

endmodule

// File: rtl/xw_mul4.sv
module xw_mul4
  import xw_mul_pkg::*;
#(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod,
  output logic           prod_vld
);

  localparam int NCOL = col_count(W);
  localparam int SUMW = col_sum_width(W);
  localparam int PW   = 2 * W;

  logic [NCOL-1:0][W-1:0]    col_bits;
  logic [NCOL:0][SUMW-1:0]   carry;
  logic [PW-1:0]             prod_comb;
  logic [SUMW-2:0]           unused_carry_hi;

  xw_pp_grid #(.W(W), .NCOL(NCOL)) u_grid (
    .a_i   (op_a),
    .b_i   (op_b),
    .col_o (col_bits)
  );

  assign carry[0] = '0;

  for (genvar c = 0; c < NCOL; c++) begin : g_cols
    xw_col_sum #(.W(W), .SUMW(SUMW)) u_col (
      .terms_i (col_bits[c]),
      .cin_i   (carry[c]),
      .bit_o   (prod_comb[c]),
      .cout_o  (carry[c+1])
    );
  end

  // Whatever leaves the highest column is the top product bit.
  assign prod_comb[PW-1] = carry[NCOL][0];
  assign unused_carry_hi = carry[NCOL][SUMW-1:1];

  xw_out_stage #(.PW(PW), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_vld),
    .prod_i (prod_comb),
    .prod_o (prod),
    .vld_o  (prod_vld)
  );

endmodule

// File: rtl/xw_mul4_chk.sv
module xw_mul4_chk #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W-1:0] prod,
  input logic           prod_vld
);

  if (REG_OUT) begin : g_reg_chk
    // R3: a flagged result is the product of the operands that were captured
    a_r3_product_match: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (prod == ($past(op_a) * $past(op_b))));

    // R2: the low product bit follows the low operand bits
    a_r2_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (prod[0] == ($past(op_a[0]) & $past(op_b[0]))));

    // R5: the flag rises one edge after an accepted pair
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> prod_vld);

    // R6: an idle cycle drops the flag and keeps the product
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!prod_vld && $stable(prod)));

    // R7: zero operand yields zero
    a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (op_a == '0 || op_b == '0)) |=> (prod == '0));
  end

endmodule

bind xw_mul4 xw_mul4_chk #(.W(W), .REG_OUT(REG_OUT)) u_xw_mul4_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .op_a     (op_a),
  .op_b     (op_b),
  .prod     (prod),
  .prod_vld (prod_vld)
);

// File: tb/tb_xw_mul4.sv
`timescale 1ns/1ps
module tb_xw_mul4;

  logic       clk;
  logic       rst_n;
  logic       in_vld;
  logic [3:0] op_a;
  logic [3:0] op_b;
  logic [7:0] prod;
  logic       prod_vld;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int exp_prod = 0;
  bit exp_vld  = 1'b0;

  xw_mul4 dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .op_a     (op_a),
    .op_b     (op_b),
    .prod     (prod),
    .prod_vld (prod_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cycles++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, advance the model at the rising
  // edge, compare half a period later.
  task automatic step(input bit v, input int a, input int b);
    @(negedge clk);
    in_vld = v;
    op_a   = 4'(a);
    op_b   = 4'(b);
    @(posedge clk);
    if (v) exp_prod = (a * b) & 255;
    exp_vld = v;
    @(negedge clk);
    check(v ? "R5" : "R6", int'(prod_vld), int'(exp_vld));
    if (!v) begin
      check("R6", int'(prod), exp_prod);
    end else if (a == 0 || b == 0) begin
      check("R7", int'(prod), exp_prod);
    end else if (a == 15 && b == 15) begin
      check("R4", int'(prod), exp_prod);
      check("R4", int'(prod[7]), 1);
    end else begin
      check("R3", int'(prod), exp_prod);
    end
    if (v) check("R2", int'(prod[0]), (a & b) & 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    op_a   = 4'd0;
    op_b   = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(prod_vld), 0);
    check("R1", int'(prod), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(prod_vld), 0);
    check("R1", int'(prod), 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(1'b1, a, b);
        if (b % 5 == 4) step(1'b0, 15 - b, a ^ 9);
      end
    end
    // back-to-back corner pairs and idle with garbage operands
    step(1'b1, 15, 15);
    step(1'b0, 0, 0);
    step(1'b0, 7, 3);
    step(1'b1, 0, 15);
    step(1'b1, 8, 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule